// File: doc/BRIEF.md
# DMA Burst Page-Boundary Splitter

This block sits between a packet DMA engine and a bus request port. It accepts one transfer descriptor at a time, holding a start byte address and a byte length. It turns the descriptor into a series of burst requests, each carrying an address and a byte length. The data path is 32 bits wide, so every address and length is a whole number of 4-byte words.

Each request is limited in three ways: by the bytes still left in the transfer, by the chunk limit (the smaller of the configured burst size, 32 bytes by default, and the maximum payload, 256 bytes by default), and by the bytes left before the next 4 KB page boundary. A burst that reaches a boundary ends on the word at page offset 0xFFC. The next request resumes at offset 0x000 of the following page.

Both sides use a valid/ready handshake. A one-cycle done pulse marks the handshake of the last piece. A descriptor with zero length, or with an address or length that is not word-aligned, raises a one-cycle error pulse and issues no request.

Top module: `dma_page_splitter`

## Requirements
- R1: `desc_ready` is high exactly when no descriptor is in progress. While a transfer runs, a descriptor held on the input is not taken, and the requests in flight keep the first descriptor's addresses.
- R2: After an accepted valid descriptor, `req_valid` rises in the next cycle, and `req_addr` equals the descriptor address.
- R3: Every `req_len` equals the minimum of three values: the remaining bytes, the chunk limit (32 with default parameters), and 4096 minus (address mod 4096). It is never zero.
- R4: No request crosses a 4 KB boundary: request address mod 4096 plus length is at most 4096. A piece that reaches a boundary is followed by a piece whose address has its low 12 bits at 0x000.
- R5: After each output handshake that is not the last, the next `req_addr` is the previous address plus the previous length. The lengths of all pieces add up to the descriptor length.
- R6: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_len` hold their values.
- R7: `done` is high only in the cycle in which the last piece of a descriptor is handshaken, and low at all other times.
- R8: A descriptor is rejected when its length is zero, when `desc_addr[1:0]` is nonzero, or when `desc_len[1:0]` is nonzero. A rejected descriptor produces `err` high for exactly one cycle, starting the cycle after acceptance. It produces no request, and `desc_ready` stays high.
- R9: After reset, `req_valid`, `done` and `err` are low and `desc_ready` is high.
- R10: When a piece is handshaken and more bytes remain, `req_valid` stays high, and the next piece is presented in the following cycle with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle, descriptor can be taken |
| desc_addr | input | ADDR_W | Start byte address |
| desc_len | input | LEN_W | Transfer length in bytes |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Burst request taken by downstream |
| req_addr | output | ADDR_W | Burst start byte address |
| req_len | output | LEN_W | Burst length in bytes |
| done | output | 1 | Last piece of the descriptor handshaken this cycle |
| err | output | 1 | Rejected descriptor pulse |

## Verification
The assertions check the following on every cycle:
- each request's length bound and page fit;
- word alignment of the requests;
- hold during stalls;
- address advance between pieces;
- that `done` and `err` fire only in their legal contexts.

Only the bench scenarios can show the rest:
- the exact sequence of piece lengths for a given descriptor, such as the split at 0xFFC/0x1000 or a 1536-byte packet at 0xC41000;
- that the lengths add up to the descriptor length;
- that a descriptor held during a busy transfer is not taken;
- that each malformed descriptor is rejected with no request.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } dps_state_e;

  localparam int WORD_BYTES = 4;
endpackage

// File: rtl/dps_desc_check.sv
module dps_desc_check #(
  parameter int LEN_W = 16
) (
  input  logic [1:0]       addr_lo,
  input  logic [LEN_W-1:0] len,
  output logic             ok
);
  // R8: zero length or sub-word address/length is illegal
  always_comb begin
    ok = (len != '0) && (addr_lo == 2'b00) && (len[1:0] == 2'b00);
  end
endmodule

// File: rtl/dps_piece_calc.sv
module dps_piece_calc #(
  parameter int LEN_W      = 16,
  parameter int CHUNK      = 32,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [$clog2(PAGE_BYTES)-1:0] page_off,
  input  logic [LEN_W-1:0]              remain,
  output logic [LEN_W-1:0]              piece
);
  localparam int PG_W = $clog2(PAGE_BYTES);
  localparam int CW   = (LEN_W > PG_W + 1) ? LEN_W : PG_W + 1;

  logic [PG_W:0] page_left;
  logic [CW-1:0] rem_x, left_x, chunk_x, m1, m2;

  // R3: piece = min(remaining, chunk, distance to page end)
  always_comb begin
    page_left = (PG_W+1)'(PAGE_BYTES) - {1'b0, page_off};
    rem_x     = CW'(remain);
    left_x    = CW'(page_left);
    chunk_x   = CW'(CHUNK);
    m1        = (rem_x < chunk_x) ? rem_x : chunk_x;
    m2        = (m1 < left_x) ? m1 : left_x;
    piece     = LEN_W'(m2);
  end
endmodule

// File: rtl/dma_page_splitter.sv
module dma_page_splitter
  import dps_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int BURST_BYTES = 32,
  parameter int MAX_PAYLOAD = 256,
  parameter int PAGE_BYTES  = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [LEN_W-1:0]  desc_len,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              done,
  output logic              err
);
  localparam int CHUNK = (BURST_BYTES < MAX_PAYLOAD) ? BURST_BYTES : MAX_PAYLOAD;
  localparam int PG_W  = $clog2(PAGE_BYTES);

  dps_state_e        state;
  logic [LEN_W-1:0]  rem;
  logic              desc_fire, req_fire, last, desc_ok;
  logic [ADDR_W-1:0] next_addr, calc_addr;
  logic [LEN_W-1:0]  next_rem, calc_rem, piece;

  assign desc_ready = (state == ST_IDLE);
  assign desc_fire  = desc_valid && desc_ready;
  assign req_fire   = req_valid && req_ready;
  assign last       = (req_len == rem);
  assign done       = req_fire && last;
  assign next_addr  = req_addr + ADDR_W'(req_len);
  assign next_rem   = rem - req_len;
  assign calc_addr  = (state == ST_IDLE) ? desc_addr : next_addr;
  assign calc_rem   = (state == ST_IDLE) ? desc_len : next_rem;

  dps_desc_check #(.LEN_W(LEN_W)) chk_i (
    .addr_lo (desc_addr[1:0]),
    .len     (desc_len),
    .ok      (desc_ok)
  );

  dps_piece_calc #(
    .LEN_W      (LEN_W),
    .CHUNK      (CHUNK),
    .PAGE_BYTES (PAGE_BYTES)
  ) calc_i (
    .page_off (calc_addr[PG_W-1:0]),
    .remain   (calc_rem),
    .piece    (piece)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_len   <= '0;
      rem       <= '0;
      err       <= 1'b0;
    end else begin
      err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (desc_fire) begin
            if (desc_ok) begin
              state     <= ST_BUSY;
              req_valid <= 1'b1;
              req_addr  <= desc_addr;
              rem       <= desc_len;
              req_len   <= piece;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_BUSY: begin
          if (req_fire) begin
            if (last) begin
              state     <= ST_IDLE;
              req_valid <= 1'b0;
            end else begin
              req_addr <= next_addr;
              rem      <= next_rem;
              req_len  <= piece;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Assertions
  a_r3_len_bound: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_len != '0) && (int'(req_len) <= CHUNK));

  a_r4_no_page_cross: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (int'(req_addr[PG_W-1:0]) + int'(req_len) <= PAGE_BYTES));

  a_r8_word_aligned: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_addr[1:0] == 2'b00) && (req_len[1:0] == 2'b00));

  a_r6_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> req_valid && $stable(req_addr) && $stable(req_len));

  a_r5_addr_advance: assert property (@(posedge clk) disable iff (rst)
    (req_fire && !done) |=> req_valid && (req_addr == $past(req_addr) + ADDR_W'($past(req_len))));

  a_r1_idle_only: assert property (@(posedge clk) disable iff (rst)
    desc_ready |-> !req_valid);

  a_r7_done_handshake: assert property (@(posedge clk) disable iff (rst)
    done |-> req_valid && req_ready);

  a_r8_err_no_req: assert property (@(posedge clk) disable iff (rst)
    err |-> !req_valid && desc_ready);
endmodule

// File: tb/dma_page_splitter_tb.sv
`timescale 1ns/1ps
module dma_page_splitter_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        desc_valid, desc_ready;
  logic [31:0] desc_addr;
  logic [15:0] desc_len;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic [15:0] req_len;
  logic        done, err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dma_page_splitter dut_i (
    .clk(clk), .rst(rst),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_addr(desc_addr), .desc_len(desc_len),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len),
    .done(done), .err(err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Drives one descriptor and checks every resulting piece against a model.
  task automatic run_xfer(input logic [31:0] a, input logic [15:0] len,
                          input int stall, input bit hold_other);
    longint exp_a = a;
    longint rem = len;
    longint sum = 0;
    int idx = 0;
    @(negedge clk);
    desc_valid = 1'b1; desc_addr = a; desc_len = len;
    @(posedge clk); #1;
    if (hold_other) desc_addr = 32'h0000_5000;
    else desc_valid = 1'b0;
    @(negedge clk);
    while (rem > 0) begin
      longint pl = 4096 - (exp_a % 4096);
      longint p = rem;
      if (p > 32) p = 32;
      if (p > pl) p = pl;
      check(req_valid == 1'b1, (idx == 0) ? "R2" : "R10", "req_valid", req_valid, 1);
      check(desc_ready == 1'b0, "R1", "desc_ready busy", desc_ready, 0);
      if (stall > 0 && idx % 2 == 0) begin
        req_ready = 1'b0;
        for (int k = 0; k < stall; k++) begin
          @(negedge clk);
          check(req_valid && req_addr == exp_a[31:0] && req_len == p[15:0],
                "R6", "stall hold", req_addr, exp_a);
          check(done == 1'b0, "R7", "done in stall", done, 0);
        end
      end
      req_ready = 1'b1;
      #0.5;
      check(req_addr == exp_a[31:0], (idx == 0) ? "R2" : "R5", "req_addr", req_addr, exp_a);
      check(req_len == p[15:0], "R3", "req_len", req_len, p);
      check((longint'(req_addr[11:0]) + longint'(req_len)) <= 4096, "R4",
            "page fit", longint'(req_addr[11:0]) + longint'(req_len), 4096);
      if (idx > 0 && (exp_a % 4096) == 0)
        check(req_addr[11:0] == 12'h000, "R4", "resume at page start", req_addr[11:0], 0);
      check(done == (rem == p), "R7", "done on piece", done, (rem == p));
      @(negedge clk);
      req_ready = 1'b0;
      exp_a += p; rem -= p; sum += p; idx++;
    end
    desc_valid = 1'b0;
    #0.5;
    check(req_valid == 1'b0, "R1", "no extra request", req_valid, 0);
    check(desc_ready == 1'b1, "R1", "ready after last", desc_ready, 1);
    check(done == 1'b0, "R7", "done after last", done, 0);
    check(sum == len, "R5", "length sum", sum, len);
  endtask

  task automatic run_bad(input logic [31:0] a, input logic [15:0] len);
    @(negedge clk);
    desc_valid = 1'b1; desc_addr = a; desc_len = len;
    @(posedge clk); #1;
    desc_valid = 1'b0;
    @(negedge clk);
    check(err == 1'b1, "R8", "err pulse", err, 1);
    check(req_valid == 1'b0, "R8", "no request", req_valid, 0);
    check(desc_ready == 1'b1, "R8", "still ready", desc_ready, 1);
    @(negedge clk);
    check(err == 1'b0, "R8", "err one cycle", err, 0);
    check(req_valid == 1'b0, "R8", "no late request", req_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; desc_valid = 1'b0; desc_addr = '0; desc_len = '0; req_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(req_valid == 0 && done == 0 && err == 0, "R9", "outputs idle", req_valid, 0);
    check(desc_ready == 1'b1, "R9", "desc_ready", desc_ready, 1);

    run_xfer(32'h0000_1000, 16'd64, 0, 1'b0);    // R3 plain chunking
    run_xfer(32'h00C4_1000, 16'd1536, 0, 1'b0);  // R5 long packet
    run_xfer(32'h0000_0FF0, 16'd64, 0, 1'b0);    // R4 split at 0xFFC
    run_xfer(32'h0000_2FFC, 16'd8, 0, 1'b0);     // R4 one-word tail
    run_xfer(32'h0000_3FE8, 16'd100, 2, 1'b0);   // R6 with stalls
    run_xfer(32'h0000_0100, 16'd4, 0, 1'b0);     // R7 single piece
    run_xfer(32'h0000_2000, 16'd96, 1, 1'b1);    // R1 held descriptor ignored
    run_bad(32'h0000_1000, 16'd0);               // R8 zero length
    run_bad(32'h0000_1002, 16'd64);              // R8 misaligned address
    run_bad(32'h0000_1000, 16'd66);              // R8 misaligned length
    run_xfer(32'h00C4_1FC0, 16'd128, 0, 1'b0);   // R2 recovery after errors

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule